// File: doc/BRIEF.md
# AUX Request to I2C Bridge Sequencer

This block takes request transactions of the kind a display auxiliary channel carries and runs them one at a time. Each request holds a 4-bit command code, a 20-bit address, a byte count from 0 to 16 and a 16-byte data buffer. When the sequence ends, the block returns a 2-bit reply code together with the buffer, which now holds any bytes that were read. Native commands are carried out one byte per cycle on a local register-space port, which answers in the same cycle. I2C-tunnelled commands become start, byte and stop operations on a byte-level I2C master. That master takes one operation per `i2c_go` pulse and answers with an `i2c_rsp` pulse.

A "middle of transaction" (MOT) flag lets one I2C transfer stay open across several requests. The sequencer remembers whether a transfer is open, and it remembers the address and command that opened it. A following MOT request with the same address and command just moves more bytes. If either one differs, the sequencer closes the old transfer with a stop and opens a new one.

Top module: `aux_i2c_seq`

## Requirements
- R1: Command codes are 4'h8 native write, 4'h9 native read, 4'h0 I2C write, 4'h1 I2C read, 4'h4 MOT I2C write and 4'h5 MOT I2C read. Reply codes are 2'd0 ACK, 2'd1 NACK and 2'd2 I2C NACK. Any other command code, or a length above 16, replies NACK. Such a request drives neither `reg_en` nor `i2c_go`, and it leaves an open I2C transfer undisturbed.
- R2: A native request accesses byte i at register address start+i, one byte per cycle. A write presents buffer byte i (bits 8i+7:8i). A read stores `reg_rdata` into response byte i. If every byte is accepted, the reply is ACK.
- R3: A native request stops at the first cycle in which `reg_err` is high, makes no further access and replies NACK. A native request with length 0 makes no access and replies NACK.
- R4: A plain (non-MOT) I2C request first issues a stop if a transfer is open. It then issues a start with address bits 6:0 and the read flag, followed by one byte operation per requested byte. Read bytes are stored into the response in order.
- R5: If the start of a plain I2C request is not acknowledged, the reply is I2C NACK and no byte or stop operation follows.
- R6: After the data phase of a plain I2C request, a stop is always issued. A byte that is not acknowledged ends the data phase and gives I2C NACK; otherwise the reply is ACK. Length 0 gives start then stop.
- R7: A MOT request issues a start if no transfer is open. If one is open and its saved address or command differs, it issues a stop followed by a new start. Otherwise it continues with byte operations only.
- R8: A MOT request whose start succeeds saves its address and command. If the start fails, the reply is I2C NACK and no transfer is left open, so the next MOT request begins with a start.
- R9: A MOT request that moves all its bytes replies ACK and issues no stop; a MOT request of length 0 issues only the start. If a byte fails, the request issues a stop and replies I2C NACK.
- R10: `req_ready` is high only when the block is idle out of reset. `done` is a single-cycle pulse carrying `reply`. `i2c_go` is a single-cycle pulse, and no register access or I2C operation happens while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted on this edge |
| req_cmd | input | 4 | Command code |
| req_addr | input | 20 | Register address or I2C target in bits 6:0 |
| req_len | input | 5 | Byte count |
| req_wdata | input | 128 | Write data, byte i in bits 8i+7:8i |
| done | output | 1 | One-cycle completion pulse |
| reply | output | 2 | Reply code, valid with done |
| rsp_data | output | 128 | Buffer with read bytes |
| reg_en | output | 1 | Register-space access strobe |
| reg_we | output | 1 | Register access is a write |
| reg_addr | output | 20 | Register byte address |
| reg_wdata | output | 8 | Register write byte |
| reg_rdata | input | 8 | Register read byte, same cycle |
| reg_err | input | 1 | Register access failed, same cycle |
| i2c_go | output | 1 | Issue one I2C operation |
| i2c_op | output | 2 | 0 start, 1 byte, 2 stop |
| i2c_dev | output | 7 | I2C target address |
| i2c_read | output | 1 | Transfer direction is read |
| i2c_wdata | output | 8 | Byte to send |
| i2c_rsp | input | 1 | Operation finished |
| i2c_nack | input | 1 | Operation not acknowledged |
| i2c_rdata | input | 8 | Byte received |

## Verification
The bench runs a chained sequence of requests in which the open-transfer state carries over from one request to the next. It checks the first I2C operation of each request and how many starts, bytes and stops each one issues. A design that compared only the address would continue across a read/write change, and one that kept the transfer open after a failed start would skip the start on the next MOT request; both give the wrong first operation or start count. It also checks that a failing byte in a MOT request adds exactly one stop, that an unsupported code between two MOT requests does not break the continuation, and that a native request stops at the first failed address. A design that kept accessing after an error would show too many register accesses.

// File: rtl/aux_i2c_pkg.sv
package aux_i2c_pkg;
  localparam int CMD_W = 4;

  typedef enum logic [1:0] {
    RPL_ACK      = 2'd0,
    RPL_NACK     = 2'd1,
    RPL_I2C_NACK = 2'd2
  } reply_e;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_BYTE  = 2'd1,
    OP_STOP  = 2'd2
  } i2c_op_e;

  typedef enum logic [1:0] {
    KIND_BAD = 2'd0,
    KIND_NAT = 2'd1,
    KIND_I2C = 2'd2
  } kind_e;

  typedef struct packed {
    kind_e kind;
    logic  rd;
    logic  mot;
  } cmd_dec_t;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_NAT   = 3'd1,
    ST_ISSUE = 3'd2,
    ST_WAIT  = 3'd3,
    ST_DONE  = 3'd4
  } seq_st_e;

  typedef enum logic [1:0] {
    PH_PRE   = 2'd0,
    PH_START = 2'd1,
    PH_DATA  = 2'd2,
    PH_POST  = 2'd3
  } phase_e;
endpackage

// File: rtl/aux_cmd_decode.sv
module aux_cmd_decode
  import aux_i2c_pkg::*;
(
  input  logic [CMD_W-1:0] cmd,
  output cmd_dec_t         dec
);
  // bit 3: native space; I2C: bit 2 = keep open, bit 1 must be clear; bit 0 = read
  always_comb begin
    dec.rd  = cmd[0];
    dec.mot = cmd[2];
    if (cmd[3]) begin
      dec.kind = (cmd[2:1] == 2'b00) ? KIND_NAT : KIND_BAD;
    end else begin
      dec.kind = cmd[1] ? KIND_BAD : KIND_I2C;
    end
  end
endmodule

// File: rtl/aux_byte_buf.sv
module aux_byte_buf #(
  parameter  int DEPTH = 16,
  localparam int IW    = $clog2(DEPTH),
  localparam int BW    = 8 * DEPTH
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [BW-1:0] load_data,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [7:0]    wdata,
  input  logic [IW-1:0] ridx,
  output logic [7:0]    rdata,
  output logic [BW-1:0] flat
);
  logic [BW-1:0]    mem_q;
  logic [DEPTH-1:0] wsel;

  for (genvar g = 0; g < DEPTH; g++) begin : g_sel
    assign wsel[g] = we && (widx == IW'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_q <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (load) begin
          mem_q[8*i +: 8] <= load_data[8*i +: 8];
        end else if (wsel[i]) begin
          mem_q[8*i +: 8] <= wdata;
        end
      end
    end
  end

  assign rdata = mem_q[{ridx, 3'b000} +: 8];
  assign flat  = mem_q;
endmodule

// File: rtl/aux_xact_track.sv
module aux_xact_track
  import aux_i2c_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_open,
  input  logic              clr_open,
  input  logic              save,
  input  logic [ADDR_W-1:0] sv_addr,
  input  logic [CMD_W-1:0]  sv_cmd,
  input  logic [ADDR_W-1:0] cmp_addr,
  input  logic [CMD_W-1:0]  cmp_cmd,
  output logic              open,
  output logic              match
);
  logic              open_q, open_d;
  logic [ADDR_W-1:0] addr_q;
  logic [CMD_W-1:0]  cmd_q;

  always_comb begin
    open_d = open_q;
    if (clr_open) begin
      open_d = 1'b0;
    end else if (set_open) begin
      open_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
    end else begin
      open_q <= open_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      cmd_q  <= '0;
    end else if (save) begin
      addr_q <= sv_addr;
      cmd_q  <= sv_cmd;
    end
  end

  assign open  = open_q;
  assign match = (addr_q == cmp_addr) && (cmd_q == cmp_cmd);
endmodule

// File: rtl/aux_i2c_seq.sv
module aux_i2c_seq
  import aux_i2c_pkg::*;
#(
  parameter  int ADDR_W  = 20,
  parameter  int MAX_LEN = 16,
  parameter  int I2C_AW  = 7,
  localparam int LEN_W   = $clog2(MAX_LEN + 1),
  localparam int IDX_W   = $clog2(MAX_LEN),
  localparam int BUF_W   = 8 * MAX_LEN
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [CMD_W-1:0]  req_cmd,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [BUF_W-1:0]  req_wdata,
  output logic              done,
  output logic [1:0]        reply,
  output logic [BUF_W-1:0]  rsp_data,
  output logic              reg_en,
  output logic              reg_we,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [7:0]        reg_wdata,
  input  logic [7:0]        reg_rdata,
  input  logic              reg_err,
  output logic              i2c_go,
  output logic [1:0]        i2c_op,
  output logic [I2C_AW-1:0] i2c_dev,
  output logic              i2c_read,
  output logic [7:0]        i2c_wdata,
  input  logic              i2c_rsp,
  input  logic              i2c_nack,
  input  logic [7:0]        i2c_rdata
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsync_q <= 2'b00;
    end else begin
      rsync_q <= {rsync_q[0], 1'b1};
    end
  end
  assign rst_i = rsync_q[1];

  seq_st_e           st_q, st_d;
  phase_e            ph_q, ph_d;
  reply_e            rpl_q, rpl_d;
  i2c_op_e           op_w;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [ADDR_W-1:0] addr_q;
  logic [CMD_W-1:0]  cmd_q;
  logic [LEN_W-1:0]  len_q;
  logic              rd_q, mot_q;
  cmd_dec_t          dec_in;
  logic              cap, last_byte;
  logic              trk_open, trk_match, trk_set, trk_clr, trk_save;
  logic              buf_we;
  logic [7:0]        buf_wd, buf_rd;

  aux_cmd_decode u_dec (
    .cmd (req_cmd),
    .dec (dec_in)
  );

  aux_xact_track #(.ADDR_W(ADDR_W)) u_trk (
    .clk      (clk),
    .rst_n    (rst_i),
    .set_open (trk_set),
    .clr_open (trk_clr),
    .save     (trk_save),
    .sv_addr  (addr_q),
    .sv_cmd   (cmd_q),
    .cmp_addr (req_addr),
    .cmp_cmd  (req_cmd),
    .open     (trk_open),
    .match    (trk_match)
  );

  aux_byte_buf #(.DEPTH(MAX_LEN)) u_buf (
    .clk       (clk),
    .rst_n     (rst_i),
    .load      (cap),
    .load_data (req_wdata),
    .we        (buf_we),
    .widx      (idx_q),
    .wdata     (buf_wd),
    .ridx      (idx_q),
    .rdata     (buf_rd),
    .flat      (rsp_data)
  );

  assign last_byte = (LEN_W'(idx_q) + LEN_W'(1)) == len_q;
  assign buf_wd    = (st_q == ST_NAT) ? reg_rdata : i2c_rdata;

  always_comb begin
    st_d     = st_q;
    ph_d     = ph_q;
    rpl_d    = rpl_q;
    idx_d    = idx_q;
    cap      = 1'b0;
    buf_we   = 1'b0;
    trk_set  = 1'b0;
    trk_clr  = 1'b0;
    trk_save = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (req_valid && req_ready) begin
          cap   = 1'b1;
          idx_d = '0;
          if (dec_in.kind == KIND_BAD || req_len > LEN_W'(MAX_LEN)) begin
            rpl_d = RPL_NACK;
            st_d  = ST_DONE;
          end else if (dec_in.kind == KIND_NAT) begin
            if (req_len == '0) begin
              rpl_d = RPL_NACK;
              st_d  = ST_DONE;
            end else begin
              st_d = ST_NAT;
            end
          end else if (!dec_in.mot) begin
            ph_d = trk_open ? PH_PRE : PH_START;
            st_d = ST_ISSUE;
          end else if (!trk_open) begin
            ph_d = PH_START;
            st_d = ST_ISSUE;
          end else if (!trk_match) begin
            ph_d = PH_PRE;
            st_d = ST_ISSUE;
          end else if (req_len == '0) begin
            rpl_d = RPL_ACK;
            st_d  = ST_DONE;
          end else begin
            ph_d = PH_DATA;
            st_d = ST_ISSUE;
          end
        end
      end
      ST_NAT: begin
        if (reg_err) begin
          rpl_d = RPL_NACK;
          st_d  = ST_DONE;
        end else begin
          buf_we = rd_q;
          if (last_byte) begin
            rpl_d = RPL_ACK;
            st_d  = ST_DONE;
          end else begin
            idx_d = idx_q + IDX_W'(1);
          end
        end
      end
      ST_ISSUE: begin
        st_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (i2c_rsp) begin
          unique case (ph_q)
            PH_PRE: begin
              trk_clr = 1'b1;
              ph_d    = PH_START;
              st_d    = ST_ISSUE;
            end
            PH_START: begin
              if (i2c_nack) begin
                rpl_d = RPL_I2C_NACK;
                st_d  = ST_DONE;
              end else begin
                trk_set  = 1'b1;
                trk_save = mot_q;
                if (len_q != '0) begin
                  ph_d = PH_DATA;
                  st_d = ST_ISSUE;
                end else if (mot_q) begin
                  rpl_d = RPL_ACK;
                  st_d  = ST_DONE;
                end else begin
                  rpl_d = RPL_ACK;
                  ph_d  = PH_POST;
                  st_d  = ST_ISSUE;
                end
              end
            end
            PH_DATA: begin
              if (i2c_nack) begin
                rpl_d = RPL_I2C_NACK;
                ph_d  = PH_POST;
                st_d  = ST_ISSUE;
              end else begin
                buf_we = rd_q;
                if (!last_byte) begin
                  idx_d = idx_q + IDX_W'(1);
                  st_d  = ST_ISSUE;
                end else if (mot_q) begin
                  rpl_d = RPL_ACK;
                  st_d  = ST_DONE;
                end else begin
                  rpl_d = RPL_ACK;
                  ph_d  = PH_POST;
                  st_d  = ST_ISSUE;
                end
              end
            end
            default: begin
              trk_clr = 1'b1;
              st_d    = ST_DONE;
            end
          endcase
        end
      end
      default: begin
        st_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      st_q  <= ST_IDLE;
      ph_q  <= PH_START;
      rpl_q <= RPL_ACK;
      idx_q <= '0;
    end else begin
      st_q  <= st_d;
      ph_q  <= ph_d;
      rpl_q <= rpl_d;
      idx_q <= idx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      addr_q <= '0;
      cmd_q  <= '0;
      len_q  <= '0;
      rd_q   <= 1'b0;
      mot_q  <= 1'b0;
    end else if (cap) begin
      addr_q <= req_addr;
      cmd_q  <= req_cmd;
      len_q  <= req_len;
      rd_q   <= dec_in.rd;
      mot_q  <= dec_in.mot;
    end
  end

  always_comb begin
    unique case (ph_q)
      PH_START: op_w = OP_START;
      PH_DATA:  op_w = OP_BYTE;
      default:  op_w = OP_STOP;
    endcase
  end

  assign req_ready = (st_q == ST_IDLE) && rst_i;
  assign done      = (st_q == ST_DONE);
  assign reply     = rpl_q;
  assign reg_en    = (st_q == ST_NAT);
  assign reg_we    = ~rd_q;
  assign reg_addr  = addr_q + ADDR_W'(idx_q);
  assign reg_wdata = buf_rd;
  assign i2c_go    = (st_q == ST_ISSUE);
  assign i2c_op    = op_w;
  assign i2c_dev   = addr_q[I2C_AW-1:0];
  assign i2c_read  = rd_q;
  assign i2c_wdata = buf_rd;
endmodule

// File: rtl/aux_i2c_seq_chk.sv
module aux_i2c_seq_chk #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              done,
  input logic [1:0]        reply,
  input logic              reg_en,
  input logic              reg_err,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              i2c_go
);
  AST_REPLY_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (reply != 2'd3)); // R1

  AST_PORT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_en && i2c_go)); // R1

  AST_NAT_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_en && $past(reg_en)) |-> (reg_addr == $past(reg_addr) + ADDR_W'(1))); // R2

  AST_NAT_STOP_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_en && reg_err) |=> !reg_en); // R3

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10

  AST_DONE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !req_ready); // R10

  AST_GO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    i2c_go |=> !i2c_go); // R10

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!reg_en && !i2c_go)); // R10
endmodule

bind aux_i2c_seq aux_i2c_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .done      (done),
  .reply     (reply),
  .reg_en    (reg_en),
  .reg_err   (reg_err),
  .reg_addr  (reg_addr),
  .i2c_go    (i2c_go)
);

// File: tb/tb_aux_i2c_seq.sv
`timescale 1ns/1ps
module tb_aux_i2c_seq;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         req_valid, req_ready;
  logic [3:0]   req_cmd;
  logic [19:0]  req_addr;
  logic [4:0]   req_len;
  logic [127:0] req_wdata;
  logic         done;
  logic [1:0]   reply;
  logic [127:0] rsp_data;
  logic         reg_en, reg_we, reg_err;
  logic [19:0]  reg_addr;
  logic [7:0]   reg_wdata, reg_rdata;
  logic         i2c_go, i2c_read, i2c_rsp, i2c_nack;
  logic [1:0]   i2c_op;
  logic [6:0]   i2c_dev;
  logic [7:0]   i2c_wdata, i2c_rdata;

  always #5 clk = ~clk;

  aux_i2c_seq dut (.*);

  // register space model: 256 bytes, error above address 0xFF
  logic [7:0] rmem [256];
  assign reg_rdata = rmem[reg_addr[7:0]];
  assign reg_err   = |reg_addr[19:8];
  int n_reg;
  always @(posedge clk) begin
    if (!rst_n) n_reg <= 0;
    else if (reg_en) begin
      n_reg <= n_reg + 1;
      if (reg_we && !reg_err) rmem[reg_addr[7:0]] <= reg_wdata;
    end
  end

  // I2C byte master model: 0x55 refuses its address, written byte 0xEE is refused
  logic       pend, p_rd;
  logic [1:0] p_op;
  logic [6:0] p_dev;
  logic [7:0] p_wd, rd_cnt;
  logic [1:0] oplog [256];
  int n_start, n_byte, n_stop, n_ops;
  always @(posedge clk) begin
    if (!rst_n) begin
      pend <= 1'b0; i2c_rsp <= 1'b0; i2c_nack <= 1'b0; i2c_rdata <= 8'h00;
      rd_cnt <= 8'h00; n_start <= 0; n_byte <= 0; n_stop <= 0; n_ops <= 0;
    end else begin
      i2c_rsp <= 1'b0;
      if (pend) begin
        pend    <= 1'b0;
        i2c_rsp <= 1'b1;
        case (p_op)
          2'd0: begin i2c_nack <= (p_dev == 7'h55); rd_cnt <= 8'h00; end
          2'd1: begin
            i2c_nack  <= !p_rd && (p_wd == 8'hEE);
            i2c_rdata <= 8'hA0 + rd_cnt;
            rd_cnt    <= rd_cnt + 8'h01;
          end
          default: i2c_nack <= 1'b0;
        endcase
      end
      if (i2c_go) begin
        pend <= 1'b1; p_op <= i2c_op; p_dev <= i2c_dev; p_wd <= i2c_wdata; p_rd <= i2c_read;
        oplog[n_ops[7:0]] <= i2c_op;
        n_ops <= n_ops + 1;
        if (i2c_op == 2'd0) n_start <= n_start + 1;
        if (i2c_op == 2'd1) n_byte  <= n_byte + 1;
        if (i2c_op == 2'd2) n_stop  <= n_stop + 1;
      end
    end
  end

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      $display("FAIL watchdog R10 actual=%0d expected=%0d", cyc, 150000);
      $display("test done: total=%0d bad=%0d", n_chk + 1, n_bad + 1);
      $finish;
    end
  end

  logic [1:0] last_rpl;
  int d_s, d_b, d_p, d_reg, first_op;

  task automatic do_req(input logic [3:0] c, input logic [19:0] a, input int l,
                        input int f, input logic [7:0] seed);
    int s0, b0, p0, o0, r0;
    int guard;
    for (int i = 0; i < 16; i++) req_wdata[8*i +: 8] = (i == f) ? 8'hEE : seed + 8'(i);
    guard = 0;
    while (!req_ready && guard < 2000) begin @(negedge clk); guard++; end
    s0 = n_start; b0 = n_byte; p0 = n_stop; o0 = n_ops; r0 = n_reg;
    req_cmd = c; req_addr = a; req_len = 5'(l); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R10 busy after accept", int'(req_ready), 0);
    guard = 0;
    while (!done && guard < 2000) begin @(negedge clk); guard++; end
    chk(done == 1'b1, "R10 done seen", int'(done), 1);
    last_rpl = reply;
    @(negedge clk);
    chk(done == 1'b0, "R10 done one cycle", int'(done), 0);
    d_s = n_start - s0; d_b = n_byte - b0; d_p = n_stop - p0; d_reg = n_reg - r0;
    first_op = (n_ops == o0) ? 3 : int'(oplog[o0[7:0]]);
  endtask

  typedef struct packed {
    logic [3:0]  cmd;
    logic [19:0] addr;
    logic [4:0]  len;
    logic [4:0]  fail;
    logic [1:0]  rpl;
    logic [1:0]  first;
    logic [2:0]  s, b, p;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 24;
  // first: 0 start, 1 byte, 2 stop, 3 no I2C operation
  localparam vec_t VEC [NV] = '{
    '{4'h8, 20'h00010, 5'd4,  5'd31, 2'd0, 2'd3, 3'd0, 3'd0, 3'd0, 4'd2},  // R2 native write
    '{4'h9, 20'h00010, 5'd4,  5'd31, 2'd0, 2'd3, 3'd0, 3'd0, 3'd0, 4'd2},  // R2 native read
    '{4'h9, 20'h000FE, 5'd4,  5'd31, 2'd1, 2'd3, 3'd0, 3'd0, 3'd0, 4'd3},  // R3 error at 0x100
    '{4'h0, 20'h00050, 5'd3,  5'd31, 2'd0, 2'd0, 3'd1, 3'd3, 3'd1, 4'd6},  // R4 R6 plain write
    '{4'h0, 20'h00055, 5'd2,  5'd31, 2'd2, 2'd0, 3'd1, 3'd0, 3'd0, 4'd5},  // R5 refused start
    '{4'h4, 20'h00050, 5'd2,  5'd31, 2'd0, 2'd0, 3'd1, 3'd2, 3'd0, 4'd9},  // R9 open
    '{4'h4, 20'h00050, 5'd2,  5'd31, 2'd0, 2'd1, 3'd0, 3'd2, 3'd0, 4'd7},  // R7 continue
    '{4'h5, 20'h00050, 5'd2,  5'd31, 2'd0, 2'd2, 3'd1, 3'd2, 3'd1, 4'd7},  // R7 command change
    '{4'h5, 20'h00052, 5'd1,  5'd31, 2'd0, 2'd2, 3'd1, 3'd1, 3'd1, 4'd7},  // R7 address change
    '{4'h1, 20'h00050, 5'd2,  5'd31, 2'd0, 2'd2, 3'd1, 3'd2, 3'd2, 4'd4},  // R4 plain over open
    '{4'h4, 20'h00050, 5'd3,  5'd1,  2'd2, 2'd0, 3'd1, 3'd2, 3'd1, 4'd9},  // R9 byte refused
    '{4'h4, 20'h00050, 5'd0,  5'd31, 2'd0, 2'd0, 3'd1, 3'd0, 3'd0, 4'd9},  // R9 zero length
    '{4'h4, 20'h00055, 5'd1,  5'd31, 2'd2, 2'd2, 3'd1, 3'd0, 3'd1, 4'd8},  // R8 refused restart
    '{4'h4, 20'h00050, 5'd1,  5'd31, 2'd0, 2'd0, 3'd1, 3'd1, 3'd0, 4'd8},  // R8 closed after fail
    '{4'h0, 20'h00050, 5'd0,  5'd31, 2'd0, 2'd2, 3'd1, 3'd0, 3'd2, 4'd6},  // R6 zero length plain
    '{4'hA, 20'h00050, 5'd1,  5'd31, 2'd1, 2'd3, 3'd0, 3'd0, 3'd0, 4'd1},  // R1 bad native code
    '{4'h2, 20'h00050, 5'd1,  5'd31, 2'd1, 2'd3, 3'd0, 3'd0, 3'd0, 4'd1},  // R1 bad I2C code
    '{4'h8, 20'h00010, 5'd0,  5'd31, 2'd1, 2'd3, 3'd0, 3'd0, 3'd0, 4'd3},  // R3 zero length
    '{4'h0, 20'h00050, 5'd3,  5'd0,  2'd2, 2'd0, 3'd1, 3'd1, 3'd1, 4'd6},  // R6 first byte refused
    '{4'h0, 20'h00050, 5'd17, 5'd31, 2'd1, 2'd3, 3'd0, 3'd0, 3'd0, 4'd1},  // R1 length 17
    '{4'h4, 20'h00050, 5'd1,  5'd31, 2'd0, 2'd0, 3'd1, 3'd1, 3'd0, 4'd7},  // R7 open again
    '{4'hF, 20'h00050, 5'd1,  5'd31, 2'd1, 2'd3, 3'd0, 3'd0, 3'd0, 4'd1},  // R1 bad code while open
    '{4'h4, 20'h00050, 5'd1,  5'd31, 2'd0, 2'd1, 3'd0, 3'd1, 3'd0, 4'd7},  // R7 still open
    '{4'h0, 20'h00050, 5'd1,  5'd31, 2'd0, 2'd2, 3'd1, 3'd1, 3'd2, 4'd4}   // R4 close
  };

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_cmd = 4'h0; req_addr = '0; req_len = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(req_ready == 1'b0, "R10 reset ready", int'(req_ready), 0);
    chk(done == 1'b0 && i2c_go == 1'b0 && reg_en == 1'b0, "R10 reset outputs",
        int'({done, i2c_go, reg_en}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(req_ready == 1'b1, "R10 ready after reset", int'(req_ready), 1);

    for (int v = 0; v < NV; v++) begin
      do_req(VEC[v].cmd, VEC[v].addr, int'(VEC[v].len), int'(VEC[v].fail), 8'h10);
      if (last_rpl != VEC[v].rpl || first_op != int'(VEC[v].first) || d_s != int'(VEC[v].s) ||
          d_b != int'(VEC[v].b) || d_p != int'(VEC[v].p)) begin
        $display("FAIL vec %0d R%0d rpl/first/S/B/P actual=%0d/%0d/%0d/%0d/%0d expected=%0d/%0d/%0d/%0d/%0d",
                 v, VEC[v].req, last_rpl, first_op, d_s, d_b, d_p,
                 VEC[v].rpl, VEC[v].first, VEC[v].s, VEC[v].b, VEC[v].p);
        n_bad++;
      end
      n_chk++;
    end

    // R2: 16-byte native write then read back, addresses increment
    do_req(4'h8, 20'h00020, 16, 31, 8'h40);
    chk(last_rpl == 2'd0 && d_reg == 16, "R2 write 16", d_reg, 16);
    do_req(4'h9, 20'h00020, 16, 31, 8'h00);
    for (int i = 0; i < 16; i++)
      chk(rsp_data[8*i +: 8] == 8'h40 + 8'(i), "R2 read byte", int'(rsp_data[8*i +: 8]), 'h40 + i);

    // R3: stop at the first failing address
    do_req(4'h8, 20'h000FD, 4, 31, 8'h70);
    chk(last_rpl == 2'd1 && d_reg == 4, "R3 stop at 0x100", d_reg, 4);
    do_req(4'h8, 20'h001FF, 3, 31, 8'h70);
    chk(last_rpl == 2'd1 && d_reg == 1, "R3 first byte fails", d_reg, 1);
    do_req(4'h9, 20'h000FD, 3, 31, 8'h00);
    chk(rsp_data[23:0] == 24'h727170, "R3 bytes before error kept", int'(rsp_data[23:0]), 'h727170);

    // R4: plain read data in order
    do_req(4'h1, 20'h00050, 3, 31, 8'h00);
    chk(last_rpl == 2'd0 && rsp_data[23:0] == 24'hA2A1A0, "R4 read data",
        int'(rsp_data[23:0]), 'hA2A1A0);

    // R7: MOT read continues the byte stream across requests
    do_req(4'h5, 20'h00050, 2, 31, 8'h00);
    chk(rsp_data[15:0] == 16'hA1A0, "R7 first MOT read", int'(rsp_data[15:0]), 'hA1A0);
    do_req(4'h5, 20'h00050, 2, 31, 8'h00);
    chk(d_s == 0 && rsp_data[15:0] == 16'hA3A2, "R7 continued MOT read",
        int'(rsp_data[15:0]), 'hA3A2);
    do_req(4'h0, 20'h00050, 0, 31, 8'h00);
    chk(d_p == 2 && last_rpl == 2'd0, "R6 close with zero length", d_p, 2);

    // R1: bad code touches nothing
    do_req(4'hB, 20'h00010, 2, 31, 8'h00);
    chk(d_reg == 0 && d_s + d_b + d_p == 0, "R1 bad code no access", d_reg + d_s + d_b + d_p, 0);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule